// File: doc/BRIEF.md
# Linked-Chunk Packet Buffer with Cached Free List

The block stores packets of any length as chains of fixed-size chunks held in an internal memory. A writer presents a packet one chunk per beat and gives the packet length, in chunks, with the first beat. Each chunk is placed at an address taken from the free list, and each stored chunk is linked to the chunk that follows it. One cycle after the final chunk is accepted, the block reports a packet pointer. That pointer is the address of the packet's first chunk.

A reader presents a packet pointer and a copy count. The block then walks the chain and streams the chunks out, one per cycle, with a flag on the final chunk. When a packet is read for the last time, each of its chunks is released as it goes out. When a packet must be read several times, its chunks are kept until the last copy has been read.

Free chunk addresses sit in a small on-chip FIFO. A larger backing FIFO, held in a synchronous RAM model, stands behind it. Chunk addresses move between the two in batches, and only when the occupancy of the small FIFO crosses its thresholds.

Top module: `chunk_pkt_buf`

## Requirements
- R1: After reset, wr_ready and rd_ready are 1, and out_valid, pkt_valid and wr_full are 0.
- R2: pkt_valid pulses for one cycle, in the cycle after the final chunk of a packet is accepted, and pkt_ptr then holds the address of that packet's first chunk. Between reset and the first release, chunk addresses are handed out in ascending order from 0.
- R3: A read request is accepted in a cycle where rd_valid and rd_ready are both 1. out_valid first rises in the second cycle after the acceptance cycle. The packet's chunks then come out on consecutive cycles, in written order, and out_last is 1 only on the final chunk.
- R4: A read whose stored copy counter is 0 and whose rd_copies is 0 or 1 releases every chunk of the packet as that chunk is streamed out.
- R5: A read whose stored copy counter is 0 and whose rd_copies is greater than 1 loads the counter with rd_copies−1 and releases nothing. Each later read of the same pointer lowers the counter by one, and rd_copies is ignored on those reads. The read that brings the counter to zero releases the chunks.
- R6: If a first beat gives wr_len greater than the number of free chunks not yet promised to a packet in progress, wr_full is 1 in that same cycle. The beat is then dropped, no chunk is allocated, and no pkt_valid follows.
- R7: Free addresses move from the small FIFO (depth CDEP) to the backing FIFO while its count exceeds HI, and back from the backing FIFO while its count is below LO, in batches of BATCH. The small FIFO never overflows, and all NCHUNK chunks can be used again after any number of fill and drain rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_first | input | 1 | Beat is the first chunk of a packet |
| wr_last | input | 1 | Beat is the final chunk of a packet |
| wr_len | input | $clog2(NCHUNK)+1 | Packet length in chunks, read on the first beat |
| wr_data | input | WORD_W*CHUNK_WORDS | Chunk payload |
| wr_ready | output | 1 | A free address is available for this beat |
| wr_full | output | 1 | First beat refused for lack of free chunks |
| pkt_valid | output | 1 | Packet fully stored |
| pkt_ptr | output | $clog2(NCHUNK) | Address of the stored packet's first chunk |
| rd_valid | input | 1 | Read request present |
| rd_ptr | input | $clog2(NCHUNK) | Packet pointer to read |
| rd_copies | input | CPY_W | Number of reads the packet will receive |
| rd_ready | output | 1 | No read in progress |
| out_valid | output | 1 | Output chunk present |
| out_data | output | WORD_W*CHUNK_WORDS | Output chunk payload |
| out_last | output | 1 | Output chunk is the packet's final chunk |

## Verification
The bench uses the default parameters: 16 chunks of four 16-bit words, a small FIFO of depth 8, LO=2, HI=5 and BATCH=2. With only four addresses in the small FIFO at reset, a 16-chunk packet drains the backing store completely and forces repeated refills with stalls on wr_ready. Releasing that packet then pushes the small FIFO past HI, which drives the drain path. The memory is small enough that a multicast hold and the refusals on full occupancy can be reached with packets of a few chunks.

// File: rtl/chunk_pkt_buf.sv
module chunk_pkt_buf #(
  parameter int WORD_W      = 16,
  parameter int CHUNK_WORDS = 4,
  parameter int NCHUNK      = 16,
  parameter int CDEP        = 8,
  parameter int LO          = 2,
  parameter int HI          = 5,
  parameter int BATCH       = 2,
  parameter int CPY_W       = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_valid,
  input  logic                              wr_first,
  input  logic                              wr_last,
  input  logic [$clog2(NCHUNK):0]           wr_len,
  input  logic [WORD_W*CHUNK_WORDS-1:0]     wr_data,
  output logic                              wr_ready,
  output logic                              wr_full,
  output logic                              pkt_valid,
  output logic [$clog2(NCHUNK)-1:0]         pkt_ptr,
  input  logic                              rd_valid,
  input  logic [$clog2(NCHUNK)-1:0]         rd_ptr,
  input  logic [CPY_W-1:0]                  rd_copies,
  output logic                              rd_ready,
  output logic                              out_valid,
  output logic [WORD_W*CHUNK_WORDS-1:0]     out_data,
  output logic                              out_last
);
  localparam int AW   = $clog2(NCHUNK);
  localparam int CW   = AW + 1;
  localparam int CAW  = $clog2(CDEP);
  localparam int CCW  = CAW + 1;
  localparam int DW   = WORD_W * CHUNK_WORDS;
  localparam int INIT = LO + BATCH;

  typedef enum logic [1:0] {MV_IDLE, MV_SPILL, MV_FILL} mv_t;

  logic [DW-1:0]     dmem [NCHUNK];
  logic [AW-1:0]     nmem [NCHUNK];
  logic [NCHUNK-1:0] lmem;
  logic [CPY_W-1:0]  cmem [NCHUNK];

  logic [AW-1:0]  cq [CDEP];
  logic [CAW-1:0] ch, ct;
  logic [CCW-1:0] cc, cc_nx;
  logic [AW-1:0]  sq [NCHUNK];
  logic [AW-1:0]  sh, st;
  logic [CW-1:0]  sc;
  mv_t            mode;
  logic [CW-1:0]  left;
  logic           rf_vld;
  logic [AW-1:0]  rf_ptr;

  logic [CW-1:0]  ftot, resv;
  logic           in_pkt;
  logic [AW-1:0]  head, prev;

  logic           rd_busy, rd_free;
  logic [AW-1:0]  rd_cur, rd_head;
  logic [CPY_W-1:0] rd_nx;

  wire [CW-1:0] avail = ftot - resv;
  assign wr_full  = wr_valid && wr_first && !in_pkt && (wr_len > avail);
  assign wr_ready = cc != '0;
  assign rd_ready = !rd_busy;

  wire          alloc   = wr_valid && wr_ready && !wr_full && (in_pkt || wr_first);
  wire [AW-1:0] aptr    = cq[ch];
  wire          spop    = (mode == MV_SPILL) && (cc > CCW'(alloc));
  wire [AW-1:0] sptr    = cq[ch + CAW'(alloc)];
  wire          fill_rd = (mode == MV_FILL) && (sc != '0);
  wire          fpush   = rd_busy && rd_free;
  wire          racc    = rd_valid && !rd_busy;
  wire [CPY_W-1:0] c0   = cmem[rd_ptr];
  wire          rlast   = (c0 == '0) ? (rd_copies <= CPY_W'(1)) : (c0 == CPY_W'(1));
  wire [CPY_W-1:0] rnx  = rlast ? '0 : ((c0 == '0) ? rd_copies - 1'b1 : c0 - 1'b1);

  assign cc_nx = cc + CCW'(fpush) + CCW'(rf_vld) - CCW'(alloc) - CCW'(spop);

  always_ff @(posedge clk) begin
    if (alloc) begin
      dmem[aptr] <= wr_data;
      lmem[aptr] <= wr_last;
      if (in_pkt) nmem[prev] <= aptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CDEP; i++) cq[i] <= (i < INIT) ? AW'(i) : '0;
      for (int i = 0; i < NCHUNK; i++) begin
        sq[i]   <= (i < NCHUNK - INIT) ? AW'(i + INIT) : '0;
        cmem[i] <= '0;
      end
      ch <= '0; ct <= CAW'(INIT); cc <= CCW'(INIT);
      sh <= '0; st <= AW'(NCHUNK - INIT); sc <= CW'(NCHUNK - INIT);
      mode <= MV_IDLE; left <= '0; rf_vld <= 1'b0; rf_ptr <= '0;
      ftot <= CW'(NCHUNK); resv <= '0; in_pkt <= 1'b0; head <= '0; prev <= '0;
      pkt_valid <= 1'b0; pkt_ptr <= '0;
      rd_busy <= 1'b0; rd_free <= 1'b0; rd_cur <= '0; rd_head <= '0; rd_nx <= '0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      if (fpush)  cq[ct] <= rd_cur;
      if (rf_vld) cq[ct + CAW'(fpush)] <= rf_ptr;
      ct <= ct + CAW'(fpush) + CAW'(rf_vld);
      ch <= ch + CAW'(alloc) + CAW'(spop);
      cc <= cc_nx;
      if (spop) begin sq[st] <= sptr; st <= st + 1'b1; end
      rf_vld <= fill_rd;
      if (fill_rd) begin rf_ptr <= sq[sh]; sh <= sh + 1'b1; end
      sc   <= sc + CW'(spop) - CW'(fill_rd);
      ftot <= ftot + CW'(fpush) - CW'(alloc);

      case (mode)
        MV_IDLE:
          if (cc_nx > CCW'(HI)) begin mode <= MV_SPILL; left <= CW'(BATCH); end
          else if (cc_nx < CCW'(LO) && sc != '0) begin mode <= MV_FILL; left <= CW'(BATCH); end
        MV_SPILL:
          if (spop) begin
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              if (cc_nx > CCW'(HI)) left <= CW'(BATCH);
              else mode <= MV_IDLE;
            end
          end
        default:
          if (!fill_rd || sc == CW'(1)) mode <= MV_IDLE;
          else begin
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              if (cc_nx < CCW'(LO)) left <= CW'(BATCH);
              else mode <= MV_IDLE;
            end
          end
      endcase

      pkt_valid <= 1'b0;
      if (alloc) begin
        prev   <= aptr;
        in_pkt <= !wr_last;
        if (!in_pkt) begin head <= aptr; resv <= wr_len - 1'b1; end
        else resv <= resv - 1'b1;
        if (wr_last) begin
          pkt_valid <= 1'b1;
          pkt_ptr   <= in_pkt ? head : aptr;
          resv      <= '0;
        end
      end

      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (racc) begin
        rd_busy <= 1'b1; rd_cur <= rd_ptr; rd_head <= rd_ptr;
        rd_free <= rlast; rd_nx <= rnx;
      end else if (rd_busy) begin
        out_valid <= 1'b1;
        out_data  <= dmem[rd_cur];
        out_last  <= lmem[rd_cur];
        rd_cur    <= nmem[rd_cur];
        if (lmem[rd_cur]) begin
          rd_busy <= 1'b0;
          cmem[rd_head] <= rd_nx;
        end
      end
    end
  end

  AST_CACHE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cc <= CCW'(CDEP)); // R7
  AST_SPILL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(mode == MV_SPILL) |-> cc > CCW'(HI)); // R7
  AST_FILL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(mode == MV_FILL) |-> cc < CCW'(LO)); // R7
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ftot <= CW'(NCHUNK)); // R4
  AST_REFUSE_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n) wr_full |=> !pkt_valid); // R6
  AST_PTR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) pkt_valid |-> $past(wr_valid && wr_last && wr_ready)); // R2
  AST_OUT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(rd_busy)); // R3
endmodule

// File: tb/chunk_pkt_buf_tb_top.sv
module chunk_pkt_buf_tb_top;
  localparam int AW = 4;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_first = 1'b0, wr_last = 1'b0;
  logic [AW:0] wr_len = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, wr_full, pkt_valid;
  logic [AW-1:0] pkt_ptr;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_ptr = '0;
  logic [2:0] rd_copies = '0;
  logic rd_ready, out_valid, out_last;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chunk_pkt_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_first(wr_first), .wr_last(wr_last), .wr_len(wr_len),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_full(wr_full),
    .pkt_valid(pkt_valid), .pkt_ptr(pkt_ptr),
    .rd_valid(rd_valid), .rd_ptr(rd_ptr), .rd_copies(rd_copies), .rd_ready(rd_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [DW-1:0] mk(int base, int i);
    logic [DW-1:0] r;
    for (int w = 0; w < 4; w++) r[w*16 +: 16] = 16'(base * 256 + i * 4 + w);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_pkt(int len, int base, output int ptr, output bit refused);
    ptr = -1; refused = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_first = (i == 0); wr_last = (i == len - 1);
      wr_len = (AW+1)'(len); wr_data = mk(base, i);
      #1;
      if (i == 0 && wr_full) begin
        refused = 1;
        @(negedge clk);
        wr_valid = 0;
        return;
      end
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 0; wr_first = 0; wr_last = 0;
    if (pkt_valid) ptr = int'(pkt_ptr);
  endtask

  task automatic read_pkt(int ptr, int copies, int len, int base, string req);
    int beats = 0;
    bit fin = 0;
    @(negedge clk);
    rd_valid = 1; rd_ptr = AW'(ptr); rd_copies = 3'(copies);
    #1;
    while (!rd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 0;
    check(!out_valid, req, "out_valid one cycle after accept", out_valid, 0);
    for (int cyc = 0; cyc < 64 && !fin; cyc++) begin
      @(negedge clk);
      if (cyc == 0) check(out_valid, req, "first beat timing", out_valid, 1);
      if (!out_valid && beats > 0) begin
        check(0, req, "gap in stream", beats, len);
        fin = 1;
      end else if (out_valid) begin
        check(out_data == mk(base, beats), req, "chunk data", out_data, mk(base, beats));
        check(out_last == (beats == len - 1), req, "last flag", out_last, beats == len - 1);
        beats++;
        if (out_last) fin = 1;
      end
    end
    check(beats == len, req, "beat count", beats, len);
  endtask

  task automatic t_reset();
    check(wr_ready == 1, "R1", "wr_ready", wr_ready, 1);
    check(rd_ready == 1, "R1", "rd_ready", rd_ready, 1);
    check(out_valid == 0, "R1", "out_valid", out_valid, 0);
    check(pkt_valid == 0, "R1", "pkt_valid", pkt_valid, 0);
    check(wr_full == 0, "R1", "wr_full", wr_full, 0);
  endtask

  int pa, pb, pc, pd, pe;
  bit rf;

  task automatic t_order();
    write_pkt(3, 1, pa, rf);
    check(!rf && pa == 0, "R2", "first packet pointer", pa, 0);
    write_pkt(5, 2, pb, rf);
    check(!rf && pb == 3, "R2", "second packet pointer", pb, 3);
  endtask

  task automatic t_unicast_and_multicast();
    read_pkt(pa, 1, 3, 1, "R3");
    read_pkt(pb, 2, 5, 2, "R5");
    write_pkt(12, 9, pc, rf);
    check(rf == 1, "R5", "held multicast chunks refuse 12", rf, 1);
    read_pkt(pb, 6, 5, 2, "R5");
    write_pkt(16, 3, pc, rf);
    check(rf == 0 && pc >= 0, "R4", "all chunks free after last copy", rf, 0);
  endtask

  task automatic t_full();
    write_pkt(1, 7, pd, rf);
    check(rf == 1, "R6", "refused when memory full", rf, 1);
    read_pkt(pc, 0, 16, 3, "R4");
    write_pkt(16, 4, pd, rf);
    check(rf == 0, "R6", "no chunk lost by refusal", rf, 0);
    read_pkt(pd, 1, 16, 4, "R7");
  endtask

  task automatic t_rounds();
    for (int r = 0; r < 3; r++) begin
      write_pkt(10, 5 + r, pd, rf);
      check(!rf, "R7", "10-chunk packet fits", rf, 0);
      write_pkt(6, 6 + r, pe, rf);
      check(!rf, "R7", "6-chunk packet fits", rf, 0);
      write_pkt(1, 8, pa, rf);
      check(rf, "R6", "17th chunk refused", rf, 1);
      read_pkt(pe, 1, 6, 6 + r, "R7");
      read_pkt(pd, 1, 10, 5 + r, "R7");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_unicast_and_multicast();
    t_full();
    t_rounds();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule